// File: doc/BRIEF.md
# Key Slot Manager for an Inline Storage Cipher

This block holds a small bank of cipher key slots for an inline block-storage encryption engine. Each slot carries a data key, plus a tweak key when the slot is set up for XTS, at either 128 or 256 bits. Software loads key material one 32-bit word at a time through a simple register port. It sets the length and mode of each slot, and picks the active slot through an index register. Key words can be written but never read back: any read in the key window returns zero. Reset is the only way to erase a key.

When the cipher datapath raises a request carrying the block count of a data unit, the block checks the slot that the index selects. It then either grants the request and presents that slot's keys on a private output port, or refuses it. A request is refused when the slot is not fully loaded, when an XTS slot holds two identical keys, or when an XTS data unit is longer than 2^20 blocks. Each refusal sets a sticky status bit for its reason, and software clears these bits by writing 1.

Top module: `kslot_mgr`

## Requirements
- R1: Key words are written at address 0x80 | slot<<4 | half<<3 | word, where half 0 is the data key and half 1 is the tweak key. The slot setup register at 0x10+slot takes bit0 = XTS and bit1 = 256-bit. Reading that register returns bit2 = valid, bit1 = 256-bit and bit0 = XTS. A slot turns valid only when every word its setup needs has been written: words 0-3 for 128 bits or words 0-7 for 256 bits of the data key, and the same set of tweak words in XTS.
- R2: A read of any address whose bit 7 is set returns zero.
- R3: Reset clears every key, slot setup, valid bit, the index register (0x02) and the status register (0x01). While reset is active and after it, every output stays at zero until a request is granted.
- R4: A request to a slot that is not valid is refused: deny_o pulses and status bit0 is set.
- R5: A request to an XTS slot whose data and tweak keys are equal over the configured length is refused and sets status bit1.
- R6: A request to an XTS slot with a block count above 2^20 is refused and sets status bit2. A count of exactly 2^20 is accepted, and ECB slots have no count limit.
- R7: Exactly one cycle after each request, either grant_o or deny_o is high. On a grant, the keys of the slot named by the index register appear on the key port. For a 128-bit slot the upper half of the key is zero, and in ECB mode the tweak output is zero.
- R8: When grant_o is low, key_data_o, key_tweak_o, key_xts_o and key_long_o are all zero.
- R9: Status bits are sticky and cleared by writing 1. If a new refusal and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: Writing a slot's setup register clears its valid bit and its load progress, so the slot must be reloaded before a grant.
- R11: When several refusal reasons apply, only one status bit is set, in the priority not-valid, then equal keys, then length.
- R12: A request checks slot state as it stood before any register write in the same cycle. A request that coincides with the final key word is still refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, zeroes all keys |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, zero when reg_rd is low |
| req_valid | input | 1 | Cipher request strobe |
| req_blocks | input | 32 | Data-unit length in cipher blocks |
| grant_o | output | 1 | Request accepted, keys valid this cycle |
| deny_o | output | 1 | Request refused |
| key_data_o | output | 256 | Data key of the selected slot |
| key_tweak_o | output | 256 | Tweak key of the selected slot |
| key_xts_o | output | 1 | Granted slot is XTS |
| key_long_o | output | 1 | Granted slot uses 256-bit keys |

## Verification
Two operations can fall in the same cycle: a request from the datapath and a register write that changes the state the request depends on. The bench forces both clashes. In the first, it writes the last key word of a slot while a request to that slot arrives, and expects a refusal followed by a grant on the next request. In the second, a refusal coincides with a write-1 clear of the status register, and the status read afterwards must still show the bit set. The scoreboard holds the expected grant or refusal and the key values for every request, and compares them against the outputs one cycle later.

// File: rtl/kslot_pkg.sv
package kslot_pkg;
   typedef enum logic [1:0] {
      DN_NONE  = 2'd0,
      DN_EMPTY = 2'd1,
      DN_SAME  = 2'd2,
      DN_LONG  = 2'd3
   } deny_e;

   typedef struct packed {
      logic lng;
      logic xts;
   } slot_cfg_t;

   localparam logic [7:0] A_STATUS = 8'h01;
   localparam logic [7:0] A_INDEX  = 8'h02;
   localparam logic [3:0] A_CFG_HI = 4'h1;
endpackage

// File: rtl/kslot_bank.sv
module kslot_bank
   import kslot_pkg::*;
#(
   parameter int unsigned SLOTS  = 8,
   parameter int unsigned KEY_W  = 256,
   parameter int unsigned WORD_W = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              key_we,
   input  logic [$clog2(SLOTS)-1:0]          key_slot,
   input  logic                              key_half,
   input  logic [$clog2(KEY_W/WORD_W)-1:0]   key_word,
   input  logic [WORD_W-1:0]                 key_wdat,
   input  logic                              cfg_we,
   input  logic [$clog2(SLOTS)-1:0]          cfg_slot,
   input  slot_cfg_t                         cfg_wdat,
   output logic [SLOTS-1:0][KEY_W-1:0]       dkey_o,
   output logic [SLOTS-1:0][KEY_W-1:0]       tkey_o,
   output slot_cfg_t [SLOTS-1:0]             cfg_o,
   output logic [SLOTS-1:0]                  valid_o,
   output logic [SLOTS-1:0]                  mode_o
);
   localparam int unsigned KW    = KEY_W / WORD_W;
   localparam int unsigned IDX_W = $clog2(SLOTS);
   localparam int unsigned MSK_W = 2 * KW;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [KEY_W-1:0] dk_q, tk_q;
      logic [MSK_W-1:0] got_q, got_nx, need;
      slot_cfg_t        cfg_q;
      logic             vld_q, mode_q;
      logic             hit_k, hit_c;

      assign hit_k = key_we && (key_slot == IDX_W'(s));
      assign hit_c = cfg_we && (cfg_slot == IDX_W'(s));

      // words this slot's setup requires before it may be used
      always_comb begin
         need = '0;
         for (int i = 0; i < KW; i++) begin
            if (cfg_q.lng || (i < KW / 2)) begin
               need[i] = 1'b1;
               if (cfg_q.xts) need[KW + i] = 1'b1;
            end
         end
      end

      assign got_nx = got_q | (MSK_W'(1) << {key_half, key_word});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dk_q   <= '0;
            tk_q   <= '0;
            got_q  <= '0;
            cfg_q  <= '0;
            vld_q  <= 1'b0;
            mode_q <= 1'b0;
         end else if (hit_c) begin
            cfg_q  <= cfg_wdat;
            got_q  <= '0;
            vld_q  <= 1'b0;
            mode_q <= 1'b0;
         end else if (hit_k) begin
            if (key_half) tk_q[key_word*WORD_W +: WORD_W] <= key_wdat;
            else          dk_q[key_word*WORD_W +: WORD_W] <= key_wdat;
            got_q <= got_nx;
            if ((got_nx & need) == need) begin
               vld_q  <= 1'b1;
               mode_q <= cfg_q.xts;
            end
         end
      end

      assign dkey_o[s]  = dk_q;
      assign tkey_o[s]  = tk_q;
      assign cfg_o[s]   = cfg_q;
      assign valid_o[s] = vld_q;
      assign mode_o[s]  = mode_q;
   end
endmodule

// File: rtl/kslot_check.sv
module kslot_check
   import kslot_pkg::*;
#(
   parameter int unsigned KEY_W    = 256,
   parameter int unsigned BLK_W    = 32,
   parameter int unsigned LIM_LOG2 = 20
) (
   input  logic             vld,
   input  logic             xts,
   input  logic             lng,
   input  logic [KEY_W-1:0] dk,
   input  logic [KEY_W-1:0] tk,
   input  logic [BLK_W-1:0] blocks,
   output logic             ok,
   output deny_e            why
);
   localparam int unsigned     HALF = KEY_W / 2;
   localparam logic [BLK_W-1:0] LIM = BLK_W'(1) << LIM_LOG2;

   logic same, big;

   assign same = lng ? (dk == tk) : (dk[HALF-1:0] == tk[HALF-1:0]);
   assign big  = blocks > LIM;

   always_comb begin
      if (!vld)             why = DN_EMPTY;
      else if (xts && same) why = DN_SAME;
      else if (xts && big)  why = DN_LONG;
      else                  why = DN_NONE;
   end

   assign ok = (why == DN_NONE);
endmodule

// File: rtl/kslot_regs.sv
module kslot_regs
   import kslot_pkg::*;
#(
   parameter int unsigned SLOTS  = 8,
   parameter int unsigned KEY_W  = 256,
   parameter int unsigned WORD_W = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_wr,
   input  logic                              reg_rd,
   input  logic [7:0]                        reg_addr,
   input  logic [WORD_W-1:0]                 reg_wdata,
   output logic [WORD_W-1:0]                 reg_rdata,
   input  deny_e                             evt,
   input  slot_cfg_t [SLOTS-1:0]             cfg_i,
   input  logic [SLOTS-1:0]                  valid_i,
   output logic [$clog2(SLOTS)-1:0]          idx_o,
   output logic                              key_we,
   output logic [$clog2(SLOTS)-1:0]          key_slot,
   output logic                              key_half,
   output logic [$clog2(KEY_W/WORD_W)-1:0]   key_word,
   output logic                              cfg_we,
   output logic [$clog2(SLOTS)-1:0]          cfg_slot,
   output slot_cfg_t                         cfg_wdat,
   output logic [2:0]                        sts_o
);
   localparam int unsigned IDX_W  = $clog2(SLOTS);
   localparam int unsigned WSEL_W = $clog2(KEY_W / WORD_W);

   logic [IDX_W-1:0]  idx_q;
   logic [2:0]        sts_q, sts_set, sts_clr;
   logic              cfg_hit;
   logic [WORD_W-1:0] rd_mux;

   // key window: bit 7 set, then slot, half, word from high to low
   assign key_we   = reg_wr && reg_addr[7];
   assign key_word = reg_addr[WSEL_W-1:0];
   assign key_half = reg_addr[WSEL_W];
   assign key_slot = reg_addr[WSEL_W+1 +: IDX_W];

   assign cfg_hit  = (reg_addr[7:4] == A_CFG_HI) && (int'(reg_addr[3:0]) < SLOTS);
   assign cfg_we   = reg_wr && cfg_hit;
   assign cfg_slot = reg_addr[IDX_W-1:0];
   assign cfg_wdat = '{lng: reg_wdata[1], xts: reg_wdata[0]};

   assign sts_set = {evt == DN_LONG, evt == DN_SAME, evt == DN_EMPTY};
   assign sts_clr = (reg_wr && reg_addr == A_STATUS) ? reg_wdata[2:0] : 3'b000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         sts_q <= '0;
      end else begin
         if (reg_wr && reg_addr == A_INDEX) idx_q <= reg_wdata[IDX_W-1:0];
         sts_q <= (sts_q & ~sts_clr) | sts_set;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (reg_addr == A_STATUS)     rd_mux[2:0] = sts_q;
      else if (reg_addr == A_INDEX) rd_mux[IDX_W-1:0] = idx_q;
      else if (cfg_hit)
         rd_mux[2:0] = {valid_i[cfg_slot], cfg_i[cfg_slot].lng, cfg_i[cfg_slot].xts};
   end

   assign reg_rdata = reg_rd ? rd_mux : '0;
   assign idx_o     = idx_q;
   assign sts_o     = sts_q;
endmodule

// File: rtl/kslot_mgr.sv
module kslot_mgr
   import kslot_pkg::*;
#(
   parameter int unsigned SLOTS    = 8,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned KEY_W    = 256,
   parameter int unsigned BLK_W    = 32,
   parameter int unsigned LIM_LOG2 = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   input  logic              req_valid,
   input  logic [BLK_W-1:0]  req_blocks,
   output logic              grant_o,
   output logic              deny_o,
   output logic [KEY_W-1:0]  key_data_o,
   output logic [KEY_W-1:0]  key_tweak_o,
   output logic              key_xts_o,
   output logic              key_long_o
);
   localparam int unsigned KW     = KEY_W / WORD_W;
   localparam int unsigned IDX_W  = $clog2(SLOTS);
   localparam int unsigned WSEL_W = $clog2(KW);
   localparam int unsigned HALF   = KEY_W / 2;

   if (KEY_W % (2 * WORD_W) != 0) begin : g_bad_key
      $error("KEY_W must be an even multiple of WORD_W");
   end
   if (SLOTS < 2 || SLOTS > 16 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two from 2 to 16");
   end
   if (WSEL_W + 1 + IDX_W > 7) begin : g_bad_map
      $error("key window does not fit below address bit 7");
   end
   if (LIM_LOG2 >= BLK_W) begin : g_bad_lim
      $error("LIM_LOG2 must be below BLK_W");
   end

   logic [SLOTS-1:0][KEY_W-1:0] dkey, tkey;
   slot_cfg_t [SLOTS-1:0]       cfg;
   logic [SLOTS-1:0]            valid, mode;
   logic [IDX_W-1:0]            idx;
   logic                        key_we, key_half, cfg_we;
   logic [IDX_W-1:0]            key_slot, cfg_slot;
   logic [WSEL_W-1:0]           key_word;
   slot_cfg_t                   cfg_wdat;
   logic [2:0]                  sts_w;
   logic                        ok;
   deny_e                       why, evt;
   logic [KEY_W-1:0]            sel_dk, sel_tk;
   logic                        sel_lng, sel_xts;

   kslot_regs #(.SLOTS(SLOTS), .KEY_W(KEY_W), .WORD_W(WORD_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .evt(evt), .cfg_i(cfg), .valid_i(valid), .idx_o(idx),
      .key_we(key_we), .key_slot(key_slot), .key_half(key_half), .key_word(key_word),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_wdat(cfg_wdat), .sts_o(sts_w)
   );

   kslot_bank #(.SLOTS(SLOTS), .KEY_W(KEY_W), .WORD_W(WORD_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .key_we(key_we), .key_slot(key_slot), .key_half(key_half),
      .key_word(key_word), .key_wdat(reg_wdata),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_wdat(cfg_wdat),
      .dkey_o(dkey), .tkey_o(tkey), .cfg_o(cfg), .valid_o(valid), .mode_o(mode)
   );

   assign sel_dk  = dkey[idx];
   assign sel_tk  = tkey[idx];
   assign sel_lng = cfg[idx].lng;
   assign sel_xts = mode[idx];

   kslot_check #(.KEY_W(KEY_W), .BLK_W(BLK_W), .LIM_LOG2(LIM_LOG2)) u_check (
      .vld(valid[idx]), .xts(sel_xts), .lng(sel_lng),
      .dk(sel_dk), .tk(sel_tk), .blocks(req_blocks),
      .ok(ok), .why(why)
   );

   assign evt = req_valid ? why : DN_NONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_o     <= 1'b0;
         deny_o      <= 1'b0;
         key_data_o  <= '0;
         key_tweak_o <= '0;
         key_xts_o   <= 1'b0;
         key_long_o  <= 1'b0;
      end else begin
         grant_o <= req_valid && ok;
         deny_o  <= req_valid && !ok;
         if (req_valid && ok) begin
            key_data_o  <= sel_lng ? sel_dk : {{HALF{1'b0}}, sel_dk[HALF-1:0]};
            key_tweak_o <= !sel_xts ? '0 :
                           (sel_lng ? sel_tk : {{HALF{1'b0}}, sel_tk[HALF-1:0]});
            key_xts_o   <= sel_xts;
            key_long_o  <= sel_lng;
         end else begin
            key_data_o  <= '0;
            key_tweak_o <= '0;
            key_xts_o   <= 1'b0;
            key_long_o  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/kslot_mgr_sva.sv
module kslot_mgr_sva
   import kslot_pkg::*;
#(
   parameter int unsigned KEY_W  = 256,
   parameter int unsigned WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [7:0]        reg_addr,
   input logic [WORD_W-1:0] reg_wdata,
   input logic [WORD_W-1:0] reg_rdata,
   input logic              req_valid,
   input logic              grant_o,
   input logic              deny_o,
   input logic [KEY_W-1:0]  key_data_o,
   input logic [KEY_W-1:0]  key_tweak_o,
   input logic              key_xts_o,
   input logic              key_long_o,
   input logic [2:0]        sts
);
   localparam int unsigned HALF = KEY_W / 2;

   p_key_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr[7]) |-> (reg_rdata == '0));

   p_deny_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
      deny_o |-> (sts != 3'b000));

   p_xts_keys_differ_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o && key_xts_o) |-> (key_data_o != key_tweak_o));

   p_one_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (grant_o ^ deny_o));

   p_answer_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o || deny_o) |-> $past(req_valid));

   p_ecb_tweak_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o && !key_xts_o) |-> (key_tweak_o == '0));

   p_short_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o && !key_long_o) |-> (key_data_o[KEY_W-1:HALF] == '0));

   p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_o |-> (key_data_o == '0 && key_tweak_o == '0 && !key_xts_o && !key_long_o));

   p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == A_STATUS) |=> ((sts & $past(sts)) == $past(sts)));

   p_single_reason_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deny_o) && $past(sts) == 3'b000 |-> $onehot0(sts));
endmodule

bind kslot_mgr kslot_mgr_sva #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .req_valid(req_valid), .grant_o(grant_o), .deny_o(deny_o),
   .key_data_o(key_data_o), .key_tweak_o(key_tweak_o),
   .key_xts_o(key_xts_o), .key_long_o(key_long_o), .sts(sts_w)
);

// File: tb/kslot_mgr_bench.sv
module kslot_mgr_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_STATUS = 8'h01;
   localparam logic [7:0] A_INDEX  = 8'h02;
   localparam logic [7:0] A_CFG    = 8'h10;

   typedef struct {
      logic         g;
      logic [255:0] d;
      logic [255:0] t;
      logic         x;
      logic         l;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0, reg_rdata;
   logic         req_valid = 1'b0;
   logic [31:0]  req_blocks = '0;
   logic         grant_o, deny_o, key_xts_o, key_long_o;
   logic [255:0] key_data_o, key_tweak_o;

   int errors = 0;
   int checks = 0;
   item_t q[$];
   logic [255:0] bdk[8], btk[8];
   bit bx[8], bl[8];

   kslot_mgr u_kslot_mgr (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_blocks(req_blocks),
      .grant_o(grant_o), .deny_o(deny_o), .key_data_o(key_data_o),
      .key_tweak_o(key_tweak_o), .key_xts_o(key_xts_o), .key_long_o(key_long_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
   end

   // monitor: compare each request's answer one cycle after it is sampled
   initial begin
      forever begin
         @(posedge clk);
         if (req_valid && rst_n) begin
            item_t e;
            @(negedge clk);
            checks++;
            if (q.size() == 0) begin
               errors++;
               $display("FAIL scoreboard empty: grant=%0b deny=%0b expected an item", grant_o, deny_o);
            end else begin
               e = q.pop_front();
               if (grant_o !== e.g || deny_o !== !e.g || key_data_o !== e.d ||
                   key_tweak_o !== e.t || key_xts_o !== e.x || key_long_o !== e.l) begin
                  errors++;
                  $display("FAIL %s: actual g=%0b dn=%0b x=%0b l=%0b d=%h t=%h expected g=%0b x=%0b l=%0b d=%h t=%h",
                           e.tag, grant_o, deny_o, key_xts_o, key_long_o, key_data_o, key_tweak_o,
                           e.g, e.x, e.l, e.d, e.t);
               end
            end
         end else begin
            @(negedge clk);
            checks++;
            if (grant_o !== 1'b0 || deny_o !== 1'b0 || key_data_o !== '0 || key_tweak_o !== '0 ||
                key_xts_o !== 1'b0 || key_long_o !== 1'b0) begin
               errors++;
               $display("FAIL R8: idle outputs actual g=%0b dn=%0b d=%h t=%h expected all zero",
                        grant_o, deny_o, key_data_o, key_tweak_o);
            end
         end
      end
   end

   function automatic logic [31:0] kval(int s, int h, int w);
      return 32'h1000_0000 * (s + 1) + h * 32'h100 + w * 32'h11 + 32'h5A;
   endfunction

   function automatic logic [7:0] kaddr(int s, int h, int w);
      return 8'h80 | 8'(s << 4) | 8'(h << 3) | 8'(w);
   endfunction

   function automatic item_t exp_ok(int s, string tag);
      item_t e;
      e.g = 1'b1;
      e.x = bx[s];
      e.l = bl[s];
      e.d = bl[s] ? bdk[s] : {128'b0, bdk[s][127:0]};
      e.t = !bx[s] ? '0 : (bl[s] ? btk[s] : {128'b0, btk[s][127:0]});
      e.tag = tag;
      return e;
   endfunction

   function automatic item_t exp_no(string tag);
      item_t e;
      e.g = 1'b0; e.x = 1'b0; e.l = 1'b0; e.d = '0; e.t = '0; e.tag = tag;
      return e;
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      checks++;
      if (reg_rdata !== exp) begin
         errors++;
         $display("FAIL %s: read addr %h actual %h expected %h", tag, a, reg_rdata, exp);
      end
      reg_rd = 1'b0;
   endtask

   task automatic wkey(int s, int h, int w, logic [31:0] v);
      wr(kaddr(s, h, w), v);
      if (h == 0) bdk[s][w*32 +: 32] = v;
      else        btk[s][w*32 +: 32] = v;
   endtask

   task automatic load(int s, bit x, bit l, bit eq);
      wr(A_CFG + 8'(s), {30'b0, l, x});
      bx[s] = x; bl[s] = l;
      for (int w = 0; w < (l ? 8 : 4); w++) begin
         wkey(s, 0, w, kval(s, 0, w));
         if (x) wkey(s, 1, w, eq ? kval(s, 0, w) : kval(s, 1, w));
      end
   endtask

   task automatic req(input logic [31:0] blocks, input item_t e);
      @(posedge clk); #1;
      req_valid = 1'b1; req_blocks = blocks;
      q.push_back(e);
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin
         bdk[i] = '0; btk[i] = '0; bx[i] = 0; bl[i] = 0;
      end
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R3: state after reset
      rd_chk(A_STATUS, 32'h0, "R3 status");
      rd_chk(A_CFG + 8'd2, 32'h0, "R3 slot setup");

      // R1 / R4: partial ECB-128 load is not usable
      wr(A_CFG + 8'd1, 32'h0);
      bx[1] = 0; bl[1] = 0;
      for (int w = 0; w < 3; w++) wkey(1, 0, w, kval(1, 0, w));
      rd_chk(A_CFG + 8'd1, 32'h0, "R1 partial not valid");
      wr(A_INDEX, 32'd1);
      req(32'd5, exp_no("R4 empty slot"));
      rd_chk(A_STATUS, 32'h1, "R4 status bit0");
      wr(A_STATUS, 32'h1);
      rd_chk(A_STATUS, 32'h0, "R9 write-1 clear");
      wkey(1, 0, 3, kval(1, 0, 3));
      rd_chk(A_CFG + 8'd1, 32'h4, "R1 valid after last word");
      rd_chk(kaddr(1, 0, 0), 32'h0, "R2 key read");
      rd_chk(kaddr(1, 1, 3), 32'h0, "R2 tweak read");
      req(32'd5, exp_ok(1, "R7 ECB-128 grant"));

      // R6: XTS-256 length limit
      load(2, 1, 1, 0);
      rd_chk(A_CFG + 8'd2, 32'h7, "R1 XTS-256 valid");
      wr(A_INDEX, 32'd2);
      req(32'h0010_0000, exp_ok(2, "R6 limit accepted"));
      req(32'h0010_0001, exp_no("R6 over limit"));
      rd_chk(A_STATUS, 32'h4, "R6 status bit2");
      wr(A_STATUS, 32'h7);

      // R5 / R11: equal XTS-128 keys, also over limit
      load(3, 1, 0, 1);
      wr(A_INDEX, 32'd3);
      req(32'h0020_0000, exp_no("R11 equal and long"));
      rd_chk(A_STATUS, 32'h2, "R11 only equal-key bit");
      req(32'd3, exp_no("R5 equal keys"));
      rd_chk(A_STATUS, 32'h2, "R5 status bit1");
      wr(A_STATUS, 32'h7);

      // R6: ECB has no length limit
      load(4, 0, 1, 0);
      wr(A_INDEX, 32'd4);
      req(32'hFFFF_FFFF, exp_ok(4, "R6 ECB no limit"));

      // R10: setup write drops validity
      wr(A_CFG + 8'd4, 32'h2);
      rd_chk(A_CFG + 8'd4, 32'h2, "R10 valid cleared");
      req(32'd1, exp_no("R10 reload needed"));
      rd_chk(A_STATUS, 32'h1, "R10 status");
      wr(A_STATUS, 32'h7);

      // R12: request in the cycle of the final key word
      wr(A_CFG + 8'd5, 32'h0);
      bx[5] = 0; bl[5] = 0;
      for (int w = 0; w < 3; w++) wkey(5, 0, w, kval(5, 0, w));
      wr(A_INDEX, 32'd5);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = kaddr(5, 0, 3); reg_wdata = kval(5, 0, 3);
      req_valid = 1'b1; req_blocks = 32'd1;
      q.push_back(exp_no("R12 same-cycle completion"));
      bdk[5][96 +: 32] = kval(5, 0, 3);
      @(posedge clk); #1;
      reg_wr = 1'b0; req_valid = 1'b0;
      rd_chk(A_CFG + 8'd5, 32'h4, "R12 valid afterwards");
      req(32'd1, exp_ok(5, "R12 next request granted"));
      wr(A_STATUS, 32'h7);

      // R9: new refusal and clear in the same cycle
      wr(A_INDEX, 32'd6);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = A_STATUS; reg_wdata = 32'h7;
      req_valid = 1'b1; req_blocks = 32'd1;
      q.push_back(exp_no("R9 refusal during clear"));
      @(posedge clk); #1;
      reg_wr = 1'b0; req_valid = 1'b0;
      rd_chk(A_STATUS, 32'h1, "R9 set wins over clear");

      // R7: index switch back to slot 1
      wr(A_INDEX, 32'd1);
      req(32'd9, exp_ok(1, "R7 index selects slot"));

      // R3: second reset wipes all state
      @(posedge clk); #1;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      rd_chk(A_STATUS, 32'h0, "R3 status after reset");
      rd_chk(A_CFG + 8'd2, 32'h0, "R3 setup after reset");
      rd_chk(A_INDEX, 32'h0, "R3 index after reset");
      wr(A_INDEX, 32'd2);
      req(32'd1, exp_no("R3 slot empty after reset"));

      repeat (3) @(posedge clk);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
      end
      finish_run();
   end
endmodule